// File: doc/BRIEF.md
# Core-Presence Snoop Filter for an Inclusive Shared Cache

This block decides, for a shared inclusive last-level cache serving several cores with private caches, which cores must be snooped. Every shared-cache line owns a small presence vector holding one bit per core. A bit is set while that core's private caches may hold a copy of the line. When a core's request finds the line in the shared cache, only the other flagged cores are snooped. When the request misses, no core is snooped at all, because inclusion guarantees the line is nowhere on the die.

The vector is kept up to date by four kinds of event. A fill marks the requester. An ownership request leaves the requester as the sole holder. A shared-cache eviction sends a back-invalidate to every flagged core and then empties the vector. A private cache may report a silent drop, which clears that core's bit. A drop that goes unreported leaves the bit set, which is safe. Along with the targets, the block reports whether a snooped copy could be modified. That is only possible when the line had exactly one holder.

The decision is registered and appears one cycle after the event. The tag and data arrays, the protocol engines and the interconnect sit outside this block. They feed it the hit/miss outcome and act on its snoop vector.

Top module: `core_presence_filter`

## Requirements
- R1: After reset every presence vector is empty and `snp_valid` is 0, so the first hit on any line snoops no core.
- R2: A miss (`req_hit`=0) produces an empty target vector, and the requester becomes the sole holder of the line, whatever bits were set before.
- R3: A read hit (`req_own`=0) targets exactly the flagged cores other than the requester, and adds the requester to the vector.
- R4: A hit on a line whose vector is empty, or whose only flagged core is the requester, produces an empty target vector.
- R5: `snp_may_dirty` is 1 exactly when the target vector is non-empty and the line's vector held exactly one bit before the event; with two or more holders it is 0.
- R6: An ownership hit (`req_own`=1) targets the other flagged cores, and afterwards the requester is the only holder.
- R7: A shared-cache eviction produces `snp_backinv`=1 with targets equal to the full vector (possibly empty), then clears the vector.
- R8: A drop report clears only the reporting core's bit for that line and produces no snoop output.
- R9: Outputs are registered. `snp_valid` is high for exactly one cycle, one cycle after each accepted request or eviction, and is low otherwise. Target bit i stands for core i, and core numbers are binary.
- R10: When several events arrive in one cycle, an eviction wins over a request, and a request wins over a drop; the losing events are discarded with no effect on any vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_core | input | CORE_W | Requesting core number |
| req_index | input | LINE_W | Shared-cache line index of the request |
| req_hit | input | 1 | 1 = line found in shared cache |
| req_own | input | 1 | 1 = ownership request, 0 = read |
| evict_valid | input | 1 | Shared cache evicts a line |
| evict_index | input | LINE_W | Line index being evicted |
| drop_valid | input | 1 | Private cache reports a silent drop |
| drop_core | input | CORE_W | Core that dropped its copy |
| drop_index | input | LINE_W | Line index dropped |
| snp_valid | output | 1 | Snoop decision present this cycle |
| snp_targets | output | NUM_CORES | Cores to snoop, bit i = core i |
| snp_backinv | output | 1 | Decision is a back-invalidate from an eviction |
| snp_may_dirty | output | 1 | A target may hold the line modified |

## Verification
On every cycle, the embedded properties check several rules. A miss never snoops. A requester is never among its own targets. The dirty flag never accompanies more than one target. An eviction always wins the cycle. A decision appears exactly one cycle after an accepted event and never at any other time. The history-dependent behaviour can only be shown through scenarios that walk one line through several events: a vector growing with reads, collapsing on ownership, losing a bit to a drop report, and being emptied by eviction. The same holds for events discarded by the priority rule.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_EVICT = 2'd1,
        OP_REQ   = 2'd2,
        OP_DROP  = 2'd3
    } op_kind_e;
endpackage

// File: rtl/sf_core_decode.sv
module sf_core_decode #(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [CORE_W-1:0]    core_id,
    output logic [NUM_CORES-1:0] core_bit
);
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_bit
        assign core_bit[g] = (core_id == CORE_W'(g));
    end
endmodule

// File: rtl/sf_op_select.sv
module sf_op_select
    import sf_pkg::*;
(
    input  logic     evict_valid,
    input  logic     req_valid,
    input  logic     drop_valid,
    output op_kind_e op_kind
);
    always_comb begin
        if (evict_valid)     op_kind = OP_EVICT;
        else if (req_valid)  op_kind = OP_REQ;
        else if (drop_valid) op_kind = OP_DROP;
        else                 op_kind = OP_NONE;
    end
endmodule

// File: rtl/sf_decide.sv
module sf_decide
    import sf_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  op_kind_e             op_kind,
    input  logic [NUM_CORES-1:0] vec_cur,
    input  logic [NUM_CORES-1:0] req_bit,
    input  logic                 req_hit,
    input  logic                 req_own,
    input  logic [NUM_CORES-1:0] drop_bit,
    output logic [NUM_CORES-1:0] vec_next,
    output logic [NUM_CORES-1:0] targets,
    output logic                 emit,
    output logic                 backinv,
    output logic                 may_dirty
);
    logic single_holder;

    always_comb begin
        vec_next = vec_cur;
        targets  = '0;
        emit     = 1'b0;
        backinv  = 1'b0;
        unique case (op_kind)
            OP_EVICT: begin
                emit     = 1'b1;
                backinv  = 1'b1;
                targets  = vec_cur;
                vec_next = '0;
            end
            OP_REQ: begin
                emit = 1'b1;
                if (!req_hit) begin
                    vec_next = req_bit;
                end else begin
                    targets  = vec_cur & ~req_bit;
                    vec_next = req_own ? req_bit : (vec_cur | req_bit);
                end
            end
            OP_DROP: begin
                vec_next = vec_cur & ~drop_bit;
            end
            default: begin
            end
        endcase
        single_holder = ($countones(vec_cur) == 1);
        may_dirty     = (targets != '0) && single_holder;
    end
endmodule

// File: rtl/core_presence_filter.sv
module core_presence_filter
    import sf_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 64,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [LINE_W-1:0]    req_index,
    input  logic                 req_hit,
    input  logic                 req_own,
    input  logic                 evict_valid,
    input  logic [LINE_W-1:0]    evict_index,
    input  logic                 drop_valid,
    input  logic [CORE_W-1:0]    drop_core,
    input  logic [LINE_W-1:0]    drop_index,
    output logic                 snp_valid,
    output logic [NUM_CORES-1:0] snp_targets,
    output logic                 snp_backinv,
    output logic                 snp_may_dirty
);
    typedef struct packed {
        logic [NUM_LINES-1:0][NUM_CORES-1:0] pres;
        logic                                valid;
        logic [NUM_CORES-1:0]                targets;
        logic                                backinv;
        logic                                may_dirty;
    } filt_state_t;

    filt_state_t st_d, st_q;

    op_kind_e             op_kind;
    logic [LINE_W-1:0]    idx_sel;
    logic [NUM_CORES-1:0] req_bit, drop_bit, vec_cur, vec_next, dec_targets;
    logic                 dec_emit, dec_backinv, dec_may_dirty;

    sf_op_select u_select (
        .evict_valid (evict_valid),
        .req_valid   (req_valid),
        .drop_valid  (drop_valid),
        .op_kind     (op_kind)
    );

    sf_core_decode #(.NUM_CORES(NUM_CORES)) u_req_dec (
        .core_id  (req_core),
        .core_bit (req_bit)
    );

    sf_core_decode #(.NUM_CORES(NUM_CORES)) u_drop_dec (
        .core_id  (drop_core),
        .core_bit (drop_bit)
    );

    always_comb begin
        unique case (op_kind)
            OP_EVICT: idx_sel = evict_index;
            OP_REQ:   idx_sel = req_index;
            OP_DROP:  idx_sel = drop_index;
            default:  idx_sel = '0;
        endcase
    end

    assign vec_cur = st_q.pres[idx_sel];

    sf_decide #(.NUM_CORES(NUM_CORES)) u_decide (
        .op_kind   (op_kind),
        .vec_cur   (vec_cur),
        .req_bit   (req_bit),
        .req_hit   (req_hit),
        .req_own   (req_own),
        .drop_bit  (drop_bit),
        .vec_next  (vec_next),
        .targets   (dec_targets),
        .emit      (dec_emit),
        .backinv   (dec_backinv),
        .may_dirty (dec_may_dirty)
    );

    always_comb begin
        st_d               = st_q;
        st_d.pres[idx_sel] = vec_next;
        st_d.valid         = dec_emit;
        st_d.targets       = dec_targets;
        st_d.backinv       = dec_backinv;
        st_d.may_dirty     = dec_may_dirty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snp_valid     = st_q.valid;
    assign snp_targets   = st_q.targets;
    assign snp_backinv   = st_q.backinv;
    assign snp_may_dirty = st_q.may_dirty;

    assert_miss_no_snoop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !evict_valid && !req_hit) |=> (snp_valid && snp_targets == '0));

    assert_no_self_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !evict_valid) |=> !snp_targets[$past(req_core)]);

    assert_dirty_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_may_dirty |-> ($countones(snp_targets) == 1));

    assert_evict_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> (snp_valid && snp_backinv));

    assert_pulse_after_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || evict_valid) |=> snp_valid);

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid || evict_valid) |=> !snp_valid);
endmodule

// File: tb/core_presence_filter_bench.sv
`timescale 1ns/1ps
module core_presence_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_hit = 1'b0, req_own = 1'b0;
    logic [1:0] req_core = '0;
    logic [5:0] req_index = '0;
    logic       evict_valid = 1'b0;
    logic [5:0] evict_index = '0;
    logic       drop_valid = 1'b0;
    logic [1:0] drop_core = '0;
    logic [5:0] drop_index = '0;
    logic       snp_valid, snp_backinv, snp_may_dirty;
    logic [3:0] snp_targets;

    int checks = 0;
    int errors = 0;
    bit monitor_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] tg;
        logic       bi;
        logic       md;
        string      rq;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    core_presence_filter u_core_presence_filter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_core(req_core), .req_index(req_index),
        .req_hit(req_hit), .req_own(req_own),
        .evict_valid(evict_valid), .evict_index(evict_index),
        .drop_valid(drop_valid), .drop_core(drop_core), .drop_index(drop_index),
        .snp_valid(snp_valid), .snp_targets(snp_targets),
        .snp_backinv(snp_backinv), .snp_may_dirty(snp_may_dirty)
    );

    // Drives one cycle of events; the expected decision is queued after the capturing edge.
    task automatic cycle(input bit ev, input logic [5:0] ei,
                         input bit rv, input logic [1:0] rc, input logic [5:0] ri,
                         input bit rh, input bit ro,
                         input bit dv, input logic [1:0] dc, input logic [5:0] di,
                         input bit expect_out, input logic [3:0] tg,
                         input bit bi, input bit md, input string rq);
        exp_t e;
        @(negedge clk);
        evict_valid = ev; evict_index = ei;
        req_valid = rv; req_core = rc; req_index = ri; req_hit = rh; req_own = ro;
        drop_valid = dv; drop_core = dc; drop_index = di;
        @(posedge clk);
        #1;
        if (expect_out) begin
            e.tg = tg; e.bi = bi; e.md = md; e.rq = rq;
            expq.push_back(e);
        end
    endtask

    task automatic rd(input logic [1:0] c, input logic [5:0] i, input logic [3:0] tg,
                      input bit md, input string rq);
        cycle(0, 0, 1, c, i, 1, 0, 0, 0, 0, 1, tg, 0, md, rq);
    endtask

    task automatic own(input logic [1:0] c, input logic [5:0] i, input logic [3:0] tg,
                       input bit md, input string rq);
        cycle(0, 0, 1, c, i, 1, 1, 0, 0, 0, 1, tg, 0, md, rq);
    endtask

    task automatic miss(input logic [1:0] c, input logic [5:0] i, input string rq);
        cycle(0, 0, 1, c, i, 0, 0, 0, 0, 0, 1, 4'b0000, 0, 0, rq);
    endtask

    task automatic evict(input logic [5:0] i, input logic [3:0] tg, input bit md,
                         input string rq);
        cycle(1, i, 0, 0, 0, 0, 0, 0, 0, 0, 1, tg, 1, md, rq);
    endtask

    task automatic drop(input logic [1:0] c, input logic [5:0] i);
        cycle(0, 0, 0, 0, 0, 0, 0, 1, c, i, 0, 4'b0, 0, 0, "");
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0, 0, 0, "");
    endtask

    // Scoreboard monitor: one comparison per cycle, away from the active edge.
    always @(negedge clk) begin
        if (monitor_on && !done) begin
            checks++;
            if (snp_valid) begin
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R9: unexpected decision, actual valid=1 expected valid=0");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (snp_targets !== e.tg || snp_backinv !== e.bi || snp_may_dirty !== e.md) begin
                        errors++;
                        $display("FAIL %s: actual tg=%b bi=%b md=%b expected tg=%b bi=%b md=%b",
                                 e.rq, snp_targets, snp_backinv, snp_may_dirty, e.tg, e.bi, e.md);
                    end
                end
            end else if (expq.size() != 0) begin
                errors++;
                $display("FAIL R9: decision missing, actual valid=0 expected valid=1 (%s)",
                         expq[0].rq);
                void'(expq.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual run unfinished expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (snp_valid !== 1'b0 || snp_targets !== 4'b0) begin
            errors++;
            $display("FAIL R1: after reset actual valid=%b tg=%b expected valid=0 tg=0000",
                     snp_valid, snp_targets);
        end
        monitor_on = 1'b1;

        rd(0, 5, 4'b0000, 0, "R1");          // empty vector after reset
        miss(1, 9, "R2");                    // line 9: {1}
        rd(2, 9, 4'b0010, 1, "R3");          // single holder -> may be dirty; {1,2}
        rd(3, 9, 4'b0110, 0, "R5");          // two holders -> clean; {1,2,3}
        own(0, 9, 4'b1110, 0, "R6");         // {0}
        rd(0, 9, 4'b0000, 0, "R4");          // requester only holder
        rd(1, 9, 4'b0001, 1, "R6");          // {0,1}
        drop(0, 9);                          // {1}
        rd(2, 9, 4'b0010, 1, "R8");          // {1,2}
        evict(9, 4'b0110, 0, "R7");          // cleared
        rd(3, 9, 4'b0000, 0, "R7");          // {3}
        // eviction, request and drop in one cycle: only the eviction acts
        cycle(1, 9, 1, 0, 9, 1, 0, 1, 3, 9, 1, 4'b1000, 1, 1, "R10");
        rd(1, 9, 4'b0000, 0, "R10");         // {1}
        // request and drop in one cycle: drop discarded
        cycle(0, 0, 1, 2, 9, 1, 0, 1, 1, 9, 1, 4'b0010, 0, 1, "R10");
        rd(0, 9, 4'b0110, 0, "R10");         // core 1 still flagged
        miss(3, 63, "R2");
        own(1, 63, 4'b1000, 1, "R6");
        evict(63, 4'b0010, 1, "R7");
        miss(2, 5, "R2");                    // line 5 was {0}, now {2}
        rd(1, 5, 4'b0100, 1, "R2");
        evict(20, 4'b0000, 0, "R7");         // empty line still answers
        idle();
        idle();
        drop(2, 5);                          // no output expected (R8)
        idle();
        rd(3, 5, 4'b0010, 1, "R8");          // line 5 now {1}
        idle();
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule